// File: doc/BRIEF.md
# Central Priority Bus Arbiter

This block decides which agent owns a shared system bus in each cycle. Four classes of agent compete for it. A memory-refresh agent ranks first. A group of DMA channels comes next, then a group of slot bus masters. The host CPU ranks last. The CPU owns the bus by default: it holds the grant whenever no other agent asks for it, and it gives the grant up as soon as anyone else requests.

Each agent has one request line and one grant line. An agent holds its request for as long as it needs the bus and releases the bus by dropping that request. Grants come from registers. At most one grant is high at a time, and an idle cycle with no grant lies between one owner and the next.

Inside the DMA class and inside the bus-master class, a round-robin pointer picks among simultaneous requesters so that each one is served in turn. A bus master that has held the bus for a parameterised number of cycles loses it when refresh or DMA is waiting. A non-maskable interrupt input hands the bus straight back to the CPU, with no idle cycle.

Top module: `bus_arbiter`

## Requirements
- R1: When the bus is free (idle cycle), a pending refresh request wins over every other request, and `ref_gnt` rises on the next clock edge.
- R2: When the bus is free and refresh is not requesting, any DMA request wins over any bus-master request, and any bus-master request wins over the CPU.
- R3: When `nmi` is high at a clock edge, the next cycle shows `cpu_gnt`=1 with all other grants 0, with no idle cycle in between. This holds for as long as `nmi` stays high.
- R4: An owner (refresh, DMA channel or bus master) keeps its grant for as long as it holds its request. The exceptions are R3 and R8. Dropping the request releases the bus.
- R5: Within the DMA class and within the bus-master class, the winner is the first requester after the last-served index, counting upward with wrap-around. After reset, the last-served index is the highest one, so index 0 is tried first. Grant bit i belongs to request bit i.
- R6: The grant vector {cpu_gnt, ref_gnt, dma_gnt, mst_gnt} has at most one bit set in every cycle.
- R7: Between the end of one owner's grant and the next grant there is exactly one cycle in which all grants are 0. The only exception is a hand-over to the CPU forced by `nmi`.
- R8: Once a bus master has held the bus for MAX_TENURE consecutive cycles (default 16), it loses the grant at the next edge if a refresh or DMA request is pending in that cycle. With nothing of higher class pending, it keeps the bus.
- R9: A low `rst_n` at a clock edge (synchronous, active low) gives `cpu_gnt`=1. The CPU keeps the bus while no other request is pending. When any other request is pending, the CPU drops its grant on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nmi | input | 1 | Non-maskable interrupt; forces ownership to the CPU |
| ref_req | input | 1 | Memory-refresh request |
| dma_req | input | N_DMA | DMA channel requests, one bit per channel |
| mst_req | input | N_MST | Slot bus-master requests, one bit per master |
| ref_gnt | output | 1 | Refresh grant |
| dma_gnt | output | N_DMA | DMA channel grants |
| mst_gnt | output | N_MST | Bus-master grants |
| cpu_gnt | output | 1 | CPU grant (default owner) |

## Verification
The case hardest to reach from the ports is tenure expiry. A bus master has to win the bus and hold its request without a break for a full MAX_TENURE cycles. Refresh has to be raised only after the master has been granted, because a refresh request raised earlier would simply win the arbitration. The bench grants master 0 alone and raises refresh in the first granted cycle. It then counts the granted cycles one by one up to the forced idle cycle and the refresh grant. A second run lets a lone master run well past the limit, to show that expiry alone does not remove the grant.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
   // Class of the current bus owner; OWN_IDLE is the hand-over gap.
   typedef enum logic [2:0] {
      OWN_IDLE = 3'd0,
      OWN_CPU  = 3'd1,
      OWN_REF  = 3'd2,
      OWN_DMA  = 3'd3,
      OWN_MST  = 3'd4
   } own_cls_e;
endpackage

// File: rtl/bus_arb_rr_pick.sv
// Round-robin selector: first requester after the last-served index (R5).
module bus_arb_rr_pick #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          any,
   output logic [IW-1:0] idx
);
   assign any = |req;

   generate
      if (N == 1) begin : g_single
         assign idx = '0;
      end else begin : g_multi
         always_comb begin
            idx = last;
            // Walk offsets from far to near; the nearest requester wins.
            for (int off = N; off >= 1; off--) begin
               if (req[(int'(last) + off) % N]) begin
                  idx = IW'((int'(last) + off) % N);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bus_arb_tenure.sv
// Counts cycles of one bus-master grant; saturates at the limit (R8).
module bus_arb_tenure #(
   parameter int MAX_TENURE = 16,
   localparam int CW = $clog2(MAX_TENURE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= '0;
      end else if (run && (cnt_q != CW'(MAX_TENURE - 1))) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = (cnt_q == CW'(MAX_TENURE - 1));
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
   import bus_arb_pkg::*;
#(
   parameter int N_DMA      = 4,
   parameter int N_MST      = 4,
   parameter int MAX_TENURE = 16,
   localparam int DW = (N_DMA > 1) ? $clog2(N_DMA) : 1,
   localparam int MW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi,
   input  logic             ref_req,
   input  logic [N_DMA-1:0] dma_req,
   input  logic [N_MST-1:0] mst_req,
   output logic             ref_gnt,
   output logic [N_DMA-1:0] dma_gnt,
   output logic [N_MST-1:0] mst_gnt,
   output logic             cpu_gnt
);
   initial begin
      if (N_DMA < 1)      $error("bus_arbiter: N_DMA must be at least 1");
      if (N_MST < 1)      $error("bus_arbiter: N_MST must be at least 1");
      if (MAX_TENURE < 2) $error("bus_arbiter: MAX_TENURE must be at least 2");
   end

   own_cls_e        cls_q, cls_n;
   // The last-served index also names the current owner inside its class.
   logic [DW-1:0]   dma_last_q, dma_last_n, dma_pick;
   logic [MW-1:0]   mst_last_q, mst_last_n, mst_pick;
   logic            dma_any, mst_any;
   logic            ten_expired, ten_start, ten_run;
   logic            upper_pending;

   bus_arb_rr_pick #(.N(N_DMA)) u_dma_pick (
      .req (dma_req), .last(dma_last_q), .any(dma_any), .idx(dma_pick)
   );

   bus_arb_rr_pick #(.N(N_MST)) u_mst_pick (
      .req (mst_req), .last(mst_last_q), .any(mst_any), .idx(mst_pick)
   );

   assign upper_pending = ref_req | dma_any;

   always_comb begin
      cls_n      = cls_q;
      dma_last_n = dma_last_q;
      mst_last_n = mst_last_q;
      if (nmi) begin
         cls_n = OWN_CPU;                                   // R3
      end else begin
         unique case (cls_q)
            OWN_CPU: if (upper_pending || mst_any) cls_n = OWN_IDLE;  // R9
            OWN_REF: if (!ref_req) cls_n = OWN_IDLE;                 // R4
            OWN_DMA: if (!dma_req[dma_last_q]) cls_n = OWN_IDLE;     // R4
            OWN_MST: if (!mst_req[mst_last_q] ||
                         (ten_expired && upper_pending)) cls_n = OWN_IDLE; // R8
            default: begin                                  // R1 R2 R7
               if (ref_req) begin
                  cls_n = OWN_REF;
               end else if (dma_any) begin
                  cls_n      = OWN_DMA;
                  dma_last_n = dma_pick;
               end else if (mst_any) begin
                  cls_n      = OWN_MST;
                  mst_last_n = mst_pick;
               end else begin
                  cls_n = OWN_CPU;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cls_q      <= OWN_CPU;
         dma_last_q <= DW'(N_DMA - 1);
         mst_last_q <= MW'(N_MST - 1);
      end else begin
         cls_q      <= cls_n;
         dma_last_q <= dma_last_n;
         mst_last_q <= mst_last_n;
      end
   end

   assign ten_start = (cls_n == OWN_MST) && (cls_q != OWN_MST);
   assign ten_run   = (cls_n == OWN_MST) && (cls_q == OWN_MST);

   bus_arb_tenure #(.MAX_TENURE(MAX_TENURE)) u_tenure (
      .clk(clk), .rst_n(rst_n), .start(ten_start), .run(ten_run),
      .expired(ten_expired)
   );

   // Grants decode the owner registers only (R6).
   assign ref_gnt = (cls_q == OWN_REF);
   assign cpu_gnt = (cls_q == OWN_CPU);

   generate
      for (genvar gd = 0; gd < N_DMA; gd++) begin : g_dma_gnt
         assign dma_gnt[gd] = (cls_q == OWN_DMA) && (dma_last_q == DW'(gd));
      end
      for (genvar gm = 0; gm < N_MST; gm++) begin : g_mst_gnt
         assign mst_gnt[gm] = (cls_q == OWN_MST) && (mst_last_q == MW'(gm));
      end
   endgenerate
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
   parameter int N_DMA      = 4,
   parameter int N_MST      = 4,
   parameter int MAX_TENURE = 16,
   localparam int GW = 2 + N_DMA + N_MST,
   localparam int HW = $clog2(MAX_TENURE + 2) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             nmi,
   input logic             ref_req,
   input logic [N_DMA-1:0] dma_req,
   input logic [N_MST-1:0] mst_req,
   input logic             ref_gnt,
   input logic [N_DMA-1:0] dma_gnt,
   input logic [N_MST-1:0] mst_gnt,
   input logic             cpu_gnt
);
   logic [GW-1:0]    gv, gv_q;
   logic             nmi_q;
   logic [N_MST-1:0] mst_q;
   logic [HW-1:0]    hold_q, hold_cur;

   assign gv = {cpu_gnt, ref_gnt, dma_gnt, mst_gnt};

   assign hold_cur = (|mst_gnt) ? ((mst_gnt == mst_q) ? hold_q + 1'b1 : HW'(1)) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gv_q   <= {1'b1, {(GW-1){1'b0}}};
         nmi_q  <= 1'b0;
         mst_q  <= '0;
         hold_q <= '0;
      end else begin
         gv_q   <= gv;
         nmi_q  <= nmi;
         mst_q  <= mst_gnt;
         hold_q <= (hold_cur > HW'(MAX_TENURE + 1)) ? HW'(MAX_TENURE + 1) : hold_cur;
      end
   end

   a_r6_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gv));

   a_r3_nmi_to_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |=> (cpu_gnt && !ref_gnt && !(|dma_gnt) && !(|mst_gnt)));

   a_r7_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ((gv != '0) && (gv_q != '0) && (gv != gv_q)) |-> nmi_q);

   a_r1_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
      ((gv == '0) && ref_req && !nmi) |=> ref_gnt);

   a_r9_default_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      ((gv == '0) && !ref_req && !(|dma_req) && !(|mst_req) && !nmi) |=> cpu_gnt);

   a_r9_cpu_yields: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt && (ref_req || (|dma_req) || (|mst_req)) && !nmi) |=> !cpu_gnt);

   a_r4_dma_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(dma_gnt & dma_req)) && !nmi) |=> (dma_gnt == $past(dma_gnt)));

   a_r8_tenure_cut: assert property (@(posedge clk) disable iff (!rst_n)
      ((|mst_gnt) && (hold_cur >= HW'(MAX_TENURE)) && (ref_req || (|dma_req)) && !nmi)
      |=> !(|mst_gnt));
endmodule

bind bus_arbiter bus_arb_chk #(
   .N_DMA(N_DMA), .N_MST(N_MST), .MAX_TENURE(MAX_TENURE)
) u_bus_arb_chk (
   .clk(clk), .rst_n(rst_n), .nmi(nmi), .ref_req(ref_req),
   .dma_req(dma_req), .mst_req(mst_req), .ref_gnt(ref_gnt),
   .dma_gnt(dma_gnt), .mst_gnt(mst_gnt), .cpu_gnt(cpu_gnt)
);

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ND  = 4;
   localparam int NM  = 4;
   localparam int TEN = 16;
   localparam int GW  = 2 + ND + NM;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nmi = 1'b0;
   logic          ref_req = 1'b0;
   logic [ND-1:0] dma_req = '0;
   logic [NM-1:0] mst_req = '0;
   logic          ref_gnt, cpu_gnt;
   logic [ND-1:0] dma_gnt;
   logic [NM-1:0] mst_gnt;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_arbiter #(.N_DMA(ND), .N_MST(NM), .MAX_TENURE(TEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .nmi(nmi), .ref_req(ref_req),
      .dma_req(dma_req), .mst_req(mst_req), .ref_gnt(ref_gnt),
      .dma_gnt(dma_gnt), .mst_gnt(mst_gnt), .cpu_gnt(cpu_gnt)
   );

   function automatic logic [GW-1:0] gvec(input logic c, input logic r,
                                          input logic [ND-1:0] d, input logic [NM-1:0] m);
      return {c, r, d, m};
   endfunction

   localparam logic [GW-1:0] IDLEV = '0;
   localparam logic [GW-1:0] CPUV  = {1'b1, {(GW-1){1'b0}}};
   localparam logic [GW-1:0] REFV  = {1'b0, 1'b1, {(GW-2){1'b0}}};

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [GW-1:0] exp);
      logic [GW-1:0] act;
      act = {cpu_gnt, ref_gnt, dma_gnt, mst_gnt};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: grants {cpu,ref,dma,mst} got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; nmi = 1'b0; ref_req = 1'b0; dma_req = '0; mst_req = '0;
      repeat (3) tick();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R9 reset gives CPU", CPUV);
      tick();
      chk("R9 CPU default, nothing pending", CPUV);
   endtask

   task automatic t_priority();
      do_reset();
      ref_req = 1'b1; dma_req = 4'b0100; mst_req = 4'b0010;
      tick(); chk("R9 R7 CPU yields into idle gap", IDLEV);
      tick(); chk("R1 R6 refresh wins over all", REFV);
      tick(); chk("R4 refresh held", REFV);
      ref_req = 1'b0;
      tick(); chk("R7 gap after refresh", IDLEV);
      tick(); chk("R2 DMA over master", gvec(0, 0, 4'b0100, '0));
      dma_req = '0;
      tick(); chk("R7 gap after DMA", IDLEV);
      tick(); chk("R2 master over CPU", gvec(0, 0, '0, 4'b0010));
      mst_req = '0;
      tick(); chk("R7 gap after master", IDLEV);
      tick(); chk("R9 CPU back when idle", CPUV);
   endtask

   task automatic t_round_robin();
      logic [ND-1:0] order [5];
      logic [ND-1:0] expg  [5];
      do_reset();
      order = '{4'b1111, 4'b1110, 4'b1101, 4'b1011, 4'b0111};
      expg  = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0001};
      for (int i = 0; i < 5; i++) begin
         dma_req = order[i];
         tick();
         if (i == 0) chk("R7 gap before first DMA", IDLEV);
         tick(); chk($sformatf("R5 DMA rotation step %0d", i), gvec(0, 0, expg[i], '0));
      end
      dma_req = '0;
      mst_req = 4'b1010;
      tick(); tick(); chk("R5 master first after last=3 is index 1", gvec(0, 0, '0, 4'b0010));
      mst_req = 4'b1000;
      tick(); tick(); chk("R5 master rotates to index 3", gvec(0, 0, '0, 4'b1000));
      mst_req = '0;
      tick(); tick(); chk("R9 CPU after rotation", CPUV);
   endtask

   task automatic t_hold();
      do_reset();
      dma_req = 4'b0001;
      tick(); tick(); chk("R2 DMA granted", gvec(0, 0, 4'b0001, '0));
      ref_req = 1'b1;
      for (int k = 0; k < 5; k++) begin
         tick(); chk("R4 DMA keeps bus while refresh waits", gvec(0, 0, 4'b0001, '0));
      end
      dma_req = '0;
      tick(); chk("R7 gap on DMA release", IDLEV);
      tick(); chk("R1 refresh served after release", REFV);
      ref_req = 1'b0;
      tick(); tick(); chk("R9 CPU after refresh", CPUV);
   endtask

   task automatic t_tenure();
      do_reset();
      mst_req = 4'b0001;
      tick(); tick(); chk("R8 master granted, cycle 1", gvec(0, 0, '0, 4'b0001));
      ref_req = 1'b1;
      for (int k = 2; k <= TEN; k++) begin
         tick(); chk($sformatf("R8 master held cycle %0d", k), gvec(0, 0, '0, 4'b0001));
      end
      tick(); chk("R8 tenure expiry forces gap", IDLEV);
      tick(); chk("R8 R1 refresh after pre-emption", REFV);
      ref_req = 1'b0;
      tick(); tick(); chk("R5 pre-empted master regains bus", gvec(0, 0, '0, 4'b0001));
      repeat (40) tick();
      chk("R8 lone master keeps bus past limit", gvec(0, 0, '0, 4'b0001));
      dma_req = 4'b0010;
      tick(); chk("R8 expired master cut for DMA", IDLEV);
      tick(); chk("R8 R2 DMA after cut", gvec(0, 0, 4'b0010, '0));
      dma_req = '0; mst_req = '0;
      tick(); tick(); chk("R9 CPU after tenure test", CPUV);
   endtask

   task automatic t_nmi();
      do_reset();
      dma_req = 4'b0100;
      tick(); tick(); chk("R2 DMA owner before NMI", gvec(0, 0, 4'b0100, '0));
      nmi = 1'b1;
      tick(); chk("R3 NMI returns bus to CPU without gap", CPUV);
      tick(); chk("R3 CPU held while NMI high", CPUV);
      nmi = 1'b0;
      tick(); chk("R9 R7 CPU yields after NMI", IDLEV);
      tick(); chk("R4 DMA regains bus", gvec(0, 0, 4'b0100, '0));
      dma_req = '0;
      tick();
      nmi = 1'b1; mst_req = 4'b0001;
      tick(); chk("R3 NMI in idle gap goes to CPU", CPUV);
      nmi = 1'b0; mst_req = '0;
      tick(); chk("R9 CPU stays, nothing pending", CPUV);
   endtask

   initial begin
      t_reset();
      t_priority();
      t_round_robin();
      t_hold();
      t_tenure();
      t_nmi();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule